// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block turns a logical address, a 16-bit selector paired with a 32-bit offset, into a 32-bit linear address. It keeps a small table of segment descriptors. Each descriptor holds a base, a limit and four permission bits. Software fills the table through a single-cycle write port.

For each request the unit picks a descriptor using the selector's index field. It adds the offset to the base, compares the offset with the limit, and tests the access type and privilege against the permission bits. One cycle later it returns either the linear address or a two-bit fault code, qualified by a valid strobe.

A descriptor with base 0 and limit 0xFFFFFFFF gives a flat segment, in which the linear address equals the offset.

Top module: `seg_xlate_unit`

## Requirements
- R1: When no fault occurs, rsp_addr equals (descriptor base + req_off) modulo 2^32.
- R2: An offset less than or equal to the descriptor limit passes the range test. An offset above the limit gives fault code 01.
- R3: Permission bits are wr_perm[0]=read, [1]=write, [2]=execute, [3]=user-accessible. Access types are req_acc 00 read, 01 write, 10 execute and 11 reserved. The access passes only when the bit for its type is set (reserved never passes) and, if req_user=1, the user bit is also set. Otherwise the fault code is 10.
- R4: The index field is req_sel[15:3]. If that field is 0 or at least 8, the request gives fault code 11. A write to table index 0 changes no response.
- R5: Fault priority is null selector (11) first, then limit (01), then permission (10). Code 00 means no fault.
- R6: A response with a nonzero fault code has rsp_addr equal to 0.
- R7: rsp_valid is high in the cycle after each cycle in which req_valid is high, and low otherwise. Back-to-back requests each get their own response.
- R8: A request in the same cycle as a descriptor write sees the old descriptor. A request in the next cycle sees the new one.
- R9: After reset, rsp_valid is low and every descriptor is base 0, limit 0 with no permissions.
- R10: A descriptor with base 0, limit 0xFFFFFFFF and all permissions maps offset 0xFFFFFFFF to linear address 0xFFFFFFFF.
- R11: Selector bits [2:0] have no effect on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 reserved |
| req_user | input | 1 | 1 = user-mode access, 0 = kernel-mode access |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | 3 | Table index to write |
| wr_base | input | 32 | Descriptor base to write |
| wr_limit | input | 32 | Descriptor limit to write |
| wr_perm | input | 4 | Permission bits to write (user, execute, write, read) |
| rsp_valid | output | 1 | Response valid |
| rsp_addr | output | 32 | Linear address, 0 on a fault |
| rsp_fault | output | 2 | Fault code |

## Verification
The assertions assume that every request and write input is driven to a known value from reset onward. The null-selector property looks one cycle back at req_sel and would misjudge an unknown selector. The bench starts all inputs at zero before reset releases. It changes them only on the falling clock edge, so each rising edge samples stable values. Reserved access codes and out-of-range selector indexes are legal stimulus and are applied on purpose, since the design defines a fault for each of them.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'b00,
      FLT_LIMIT = 2'b01,
      FLT_PERM  = 2'b10,
      FLT_NULL  = 2'b11
   } seg_fault_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_EXEC  = 2'b10,
      ACC_RSVD  = 2'b11
   } seg_acc_e;

   localparam int PERM_W = 4;
   localparam int PERM_R = 0;
   localparam int PERM_WR = 1;
   localparam int PERM_X = 2;
   localparam int PERM_U = 3;

endpackage

// File: rtl/seg_desc_table.sv
`timescale 1ns/1ps
module seg_desc_table #(
   parameter int NUM_DESC = 8,
   parameter int ADDR_W   = 32,
   parameter int PERM_W   = 4,
   localparam int IDX_W   = $clog2(NUM_DESC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [ADDR_W-1:0] wr_limit,
   input  logic [PERM_W-1:0] wr_perm,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_base,
   output logic [ADDR_W-1:0] rd_limit,
   output logic [PERM_W-1:0] rd_perm
);

   logic [ADDR_W-1:0] base_q  [NUM_DESC];
   logic [ADDR_W-1:0] limit_q [NUM_DESC];
   logic [PERM_W-1:0] perm_q  [NUM_DESC];

   // Entry 0 is the null slot: it is never written and stays cleared.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_DESC; i++) begin
            base_q[i]  <= '0;
            limit_q[i] <= '0;
            perm_q[i]  <= '0;
         end
      end else begin
         for (int i = 1; i < NUM_DESC; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
               base_q[i]  <= wr_base;
               limit_q[i] <= wr_limit;
               perm_q[i]  <= wr_perm;
            end
         end
      end
   end

   assign rd_base  = base_q[rd_idx];
   assign rd_limit = limit_q[rd_idx];
   assign rd_perm  = perm_q[rd_idx];

   // R4: the null slot keeps its cleared contents whatever is written
   a_r4_null_slot_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (base_q[0] == '0) && (limit_q[0] == '0) && (perm_q[0] == '0));

endmodule

// File: rtl/seg_check.sv
`timescale 1ns/1ps
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_null,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] limit,
   input  logic [PERM_W-1:0] perm,
   input  logic [ADDR_W-1:0] off,
   input  logic [1:0]        acc,
   input  logic              user,
   output logic [ADDR_W-1:0] lin_addr,
   output seg_fault_e        fault
);

   logic              in_range;
   logic              type_ok;
   logic              priv_ok;
   logic [ADDR_W-1:0] sum;

   always_comb begin
      in_range = (off <= limit);
      unique case (seg_acc_e'(acc))
         ACC_READ:  type_ok = perm[PERM_R];
         ACC_WRITE: type_ok = perm[PERM_WR];
         ACC_EXEC:  type_ok = perm[PERM_X];
         default:   type_ok = 1'b0;
      endcase
      priv_ok = !user || perm[PERM_U];
      sum     = base + off;

      if (sel_null)                  fault = FLT_NULL;
      else if (!in_range)            fault = FLT_LIMIT;
      else if (!(type_ok && priv_ok)) fault = FLT_PERM;
      else                           fault = FLT_NONE;

      lin_addr = (fault == FLT_NONE) ? sum : '0;
   end

   // R2: an offset past the limit on a non-null selector must report a limit fault
   a_r2_over_limit : assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_null && (off > limit)) |-> (fault == FLT_LIMIT));

   // R5: a permission fault only appears once the range test has passed
   a_r5_perm_in_range : assert property (@(posedge clk) disable iff (!rst_n)
      (fault == FLT_PERM) |-> (off <= limit));

endmodule

// File: rtl/seg_xlate_unit.sv
`timescale 1ns/1ps
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int SEL_W    = 16,
   parameter int ADDR_W   = 32,
   parameter int NUM_DESC = 8,
   parameter int IDX_LSB  = 3,
   localparam int IDX_W   = $clog2(NUM_DESC),
   localparam int FIELD_W = SEL_W - IDX_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [SEL_W-1:0]  req_sel,
   input  logic [ADDR_W-1:0] req_off,
   input  logic [1:0]        req_acc,
   input  logic              req_user,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [ADDR_W-1:0] wr_limit,
   input  logic [PERM_W-1:0] wr_perm,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [1:0]        rsp_fault
);

   generate
      if (NUM_DESC < 2 || (NUM_DESC & (NUM_DESC - 1)) != 0) begin : g_bad_depth
         $error("seg_xlate_unit: NUM_DESC must be a power of two of at least 2");
      end
      if (FIELD_W < IDX_W) begin : g_bad_field
         $error("seg_xlate_unit: selector index field narrower than table index");
      end
   endgenerate

   logic [FIELD_W-1:0] idx_field;
   logic               sel_null;
   logic [ADDR_W-1:0]  d_base, d_limit;
   logic [PERM_W-1:0]  d_perm;
   logic [ADDR_W-1:0]  lin_addr;
   seg_fault_e         fault;

   assign idx_field = req_sel[SEL_W-1:IDX_LSB];
   assign sel_null  = (idx_field == '0) || (idx_field > FIELD_W'(NUM_DESC - 1));

   seg_desc_table #(
      .NUM_DESC (NUM_DESC),
      .ADDR_W   (ADDR_W),
      .PERM_W   (PERM_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_base  (wr_base),
      .wr_limit (wr_limit),
      .wr_perm  (wr_perm),
      .rd_idx   (idx_field[IDX_W-1:0]),
      .rd_base  (d_base),
      .rd_limit (d_limit),
      .rd_perm  (d_perm)
   );

   seg_check #(
      .ADDR_W (ADDR_W)
   ) u_check (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_null (sel_null),
      .base     (d_base),
      .limit    (d_limit),
      .perm     (d_perm),
      .off      (req_off),
      .acc      (req_acc),
      .user     (req_user),
      .lin_addr (lin_addr),
      .fault    (fault)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_addr  <= '0;
         rsp_fault <= FLT_NONE;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_addr  <= lin_addr;
            rsp_fault <= fault;
         end
      end
   end

   // R7: every request cycle yields a response in the next cycle
   a_r7_rsp_follows : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R7: no response without a request in the previous cycle
   a_r7_rsp_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R6: a faulted response carries no address
   a_r6_fault_zero_addr : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_fault != FLT_NONE)) |-> (rsp_addr == '0));

   // R4: a zero index field always ends in a null-selector fault
   a_r4_null_index : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_sel[SEL_W-1:IDX_LSB] == '0)) |=> (rsp_fault == FLT_NULL));

endmodule

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;

   localparam time CYC = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_sel = '0;
   logic [31:0] req_off = '0;
   logic [1:0]  req_acc = '0;
   logic        req_user = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [31:0] wr_base = '0;
   logic [31:0] wr_limit = '0;
   logic [3:0]  wr_perm = '0;
   logic        rsp_valid;
   logic [31:0] rsp_addr;
   logic [1:0]  rsp_fault;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CYC/2) clk = ~clk;

   seg_xlate_unit u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
      .req_off(req_off), .req_acc(req_acc), .req_user(req_user),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_limit(wr_limit),
      .wr_perm(wr_perm), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
      .rsp_fault(rsp_fault)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_desc(input logic [2:0] idx, input logic [31:0] b,
                          input logic [31:0] l, input logic [3:0] p);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_base = b; wr_limit = l; wr_perm = p;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic drive_req(input logic [15:0] s, input logic [31:0] o,
                            input logic [1:0] a, input logic u);
      req_valid = 1'b1; req_sel = s; req_off = o; req_acc = a; req_user = u;
   endtask

   task automatic check_rsp(input string tag, input logic [31:0] ea, input logic [1:0] ef);
      chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
      chk({tag, " addr"}, rsp_addr, ea);
      chk({tag, " fault"}, 32'(rsp_fault), 32'(ef));
   endtask

   task automatic do_req(input string tag, input logic [15:0] s, input logic [31:0] o,
                         input logic [1:0] a, input logic u,
                         input logic [31:0] ea, input logic [1:0] ef);
      @(negedge clk);
      drive_req(s, o, a, u);
      @(posedge clk);
      #2;
      check_rsp(tag, ea, ef);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset;
      #2;
      chk("R9 reset valid low", 32'(rsp_valid), 32'd0);
      do_req("R9 cleared entry perm", 16'h0008, 32'h0, 2'b00, 1'b0, 32'h0, 2'b10);
      do_req("R5 cleared entry limit first", 16'h0008, 32'h1, 2'b00, 1'b0, 32'h0, 2'b01);
   endtask

   task automatic t_data_seg;
      wr_desc(3'd1, 32'h1000_0000, 32'h0000_0FFF, 4'h3);
      do_req("R1 data read", 16'h0008, 32'h123, 2'b00, 1'b0, 32'h1000_0123, 2'b00);
      do_req("R2 at limit", 16'h0008, 32'hFFF, 2'b01, 1'b0, 32'h1000_0FFF, 2'b00);
      do_req("R2 past limit", 16'h0008, 32'h1000, 2'b00, 1'b0, 32'h0, 2'b01);
      do_req("R3 exec denied", 16'h0008, 32'h10, 2'b10, 1'b0, 32'h0, 2'b10);
      do_req("R3 user denied", 16'h0008, 32'h10, 2'b00, 1'b1, 32'h0, 2'b10);
      do_req("R3 reserved type", 16'h0008, 32'h10, 2'b11, 1'b0, 32'h0, 2'b10);
      do_req("R5 limit over perm", 16'h0008, 32'h1000, 2'b10, 1'b1, 32'h0, 2'b01);
      do_req("R11 low bits ignored", 16'h000F, 32'h10, 2'b00, 1'b0, 32'h1000_0010, 2'b00);
   endtask

   task automatic t_code_seg;
      wr_desc(3'd2, 32'hFFFF_F000, 32'h0000_2000, 4'hD);
      do_req("R1 wrap user exec", 16'h0010, 32'h1800, 2'b10, 1'b1, 32'h0000_0800, 2'b00);
      do_req("R3 code write denied", 16'h0010, 32'h1800, 2'b01, 1'b1, 32'h0, 2'b10);
   endtask

   task automatic t_flat;
      wr_desc(3'd3, 32'h0, 32'hFFFF_FFFF, 4'hF);
      do_req("R10 flat top", 16'h0018, 32'hFFFF_FFFF, 2'b00, 1'b1, 32'hFFFF_FFFF, 2'b00);
   endtask

   task automatic t_null;
      do_req("R4 null selector", 16'h0000, 32'h0, 2'b00, 1'b0, 32'h0, 2'b11);
      wr_desc(3'd0, 32'h0, 32'hFFFF_FFFF, 4'hF);
      do_req("R4 write to slot 0 ignored", 16'h0003, 32'h4, 2'b00, 1'b0, 32'h0, 2'b11);
      do_req("R4 index out of table", 16'h0040, 32'h4, 2'b00, 1'b0, 32'h0, 2'b11);
      do_req("R5 null over limit", 16'h0000, 32'hFFFF_0000, 2'b11, 1'b1, 32'h0, 2'b11);
   endtask

   task automatic t_write_timing;
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 3'd4; wr_base = 32'h2000; wr_limit = 32'hFF; wr_perm = 4'h1;
      drive_req(16'h0020, 32'h10, 2'b00, 1'b0);
      @(posedge clk);
      #2;
      check_rsp("R8 same cycle old", 32'h0, 2'b01);
      @(negedge clk);
      wr_en = 1'b0;
      @(posedge clk);
      #2;
      check_rsp("R8 next cycle new", 32'h2010, 2'b00);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      drive_req(16'h0008, 32'h20, 2'b00, 1'b0);
      @(posedge clk);
      #2;
      check_rsp("R7 first", 32'h1000_0020, 2'b00);
      @(negedge clk);
      drive_req(16'h0018, 32'h55, 2'b01, 1'b0);
      @(posedge clk);
      #2;
      check_rsp("R7 second", 32'h55, 2'b00);
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk);
      #2;
      chk("R7 idle after burst", 32'(rsp_valid), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_data_seg();
      t_code_seg();
      t_flat();
      t_null();
      t_write_timing();
      t_back_to_back();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CYC * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule